// File: doc/BRIEF.md
# Three-Phase Leg Interlock with Deadtime

This block sits between six active-high PWM commands, one high-side and one low-side request for each of the three bridge legs, and six gate-enable outputs. Each command first crosses a two-flop synchronizer. A level filter then passes a new level only after that level has been held for `N_FILT` clock cycles, so short pulses are dropped on both rising and falling edges.

After filtering, a per-leg arbiter makes sure the two switches of a leg are never enabled together. The side whose filtered request arrived first owns the leg until that request drops. If both requests arrive in the same cycle, the leg stays off until one of them releases. Whenever a switch turns off, either because its owner released or because of a trip, the leg waits `N_DEAD` cycles before any switch of that leg may turn on. The three legs run independently of each other.

A global trip input from the protection logic turns all six outputs off in the same cycle. When the trip is released, the filtered requests are evaluated again, and no output turns on until a full deadtime has passed. All timing values are parameters counted in clock cycles. Leg index 0 is phase U, 1 is phase V and 2 is phase W.

Top module: `gate_interlock`

## Requirements
- R1: While reset is asserted, and at the first edges after it is released, every gate output is 0. The deadtime counter starts out already expired.
- R2: A command level that is new and that the synchronizer sees for fewer than `N_FILT` cycles has no effect on the outputs. A level held for exactly `N_FILT` cycles is passed.
- R3: If a leg is idle with its deadtime expired and one command of that leg rises, the matching output goes to 1 on the (`N_FILT`+3)-th rising edge that samples the new level. It is still 0 one edge earlier.
- R4: A low-going dropout shorter than `N_FILT` cycles on an owned command leaves that output at 1.
- R5: The high-side and low-side outputs of one leg are never 1 in the same cycle.
- R6: While one side owns a leg and its request stays active, raising the other side's request changes neither output of that leg.
- R7: When the owner's request drops while the opposite request is held, the owner's output goes to 0 on the (`N_FILT`+3)-th edge after the drop. The opposite output goes to 1 exactly `N_DEAD` edges later.
- R8: If both requests of a leg become active in the same cycle, both outputs stay at 0. When one request is then released, the other output goes to 1 on the (`N_FILT`+3)-th edge after that release.
- R9: While the trip input is 1, all six outputs are 0, starting in the same cycle in which the trip goes to 1.
- R10: After the trip falls, all outputs stay at 0 for `N_DEAD`-1 edges. A request that is still held turns its output back on at the `N_DEAD`-th edge.
- R11: Commands on one leg have no effect on the outputs of the other legs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_hi_i | input | N_LEGS | High-side on-requests, bit 0 = U, 1 = V, 2 = W |
| cmd_lo_i | input | N_LEGS | Low-side on-requests, same bit order |
| trip_i | input | 1 | Global protection trip; 1 forces all outputs off |
| gate_hi_o | output | N_LEGS | High-side gate enables |
| gate_lo_o | output | N_LEGS | Low-side gate enables |

## Verification
The stimulus covers the following cases, each of which separates a different behaviour:
- A single request from idle fixes the turn-on latency edge by edge.
- Pulses of `N_FILT`-1 and of exactly `N_FILT` cycles mark the boundary of the filter. A short dropout on an owned request shows that the filter also acts on release.
- A late opposite request shows that the first side keeps the leg. Releasing the owner then places the handover gap at exactly `N_DEAD` cycles.
- Simultaneous requests show that the leg stays off until one side lets go.
- A trip applied over a held request shows both the forced-off state and the delayed resume.
- Mixed activity on two legs shows that the legs do not affect each other.

// File: rtl/gi_pkg.sv
package gi_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HI   = 2'd1,
    OWN_LO   = 2'd2
  } owner_e;
endpackage

// File: rtl/gi_sync.sv
module gi_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d_i;
      hold_q <= meta_q;
    end
  end

  assign q_o = hold_q;
endmodule

// File: rtl/gi_filter.sv
module gi_filter #(
  parameter int N_FILT = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic lvl_o
);
  localparam int CW = $clog2(N_FILT + 1);

  logic [CW-1:0] run_q;
  logic          lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (lvl_i != lvl_q) begin
      if (run_q == CW'(N_FILT - 1)) begin
        lvl_q <= lvl_i;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign lvl_o = lvl_q;

  // R2
  filt_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(lvl_i) == lvl_q));
endmodule

// File: rtl/gi_arbiter.sv
module gi_arbiter
  import gi_pkg::*;
#(
  parameter int N_DEAD = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_req_i,
  input  logic lo_req_i,
  input  logic trip_i,
  output logic hi_o,
  output logic lo_o
);
  localparam int DW = $clog2(N_DEAD + 1);

  owner_e        own_q;
  logic [DW-1:0] dead_q;
  logic          release_w;

  assign release_w = ((own_q == OWN_HI) && !hi_req_i) ||
                     ((own_q == OWN_LO) && !lo_req_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= OWN_NONE;
      dead_q <= '0;
    end else begin
      if (trip_i || release_w)
        dead_q <= DW'(N_DEAD);
      else if (dead_q != '0)
        dead_q <= dead_q - 1'b1;

      if (trip_i || release_w)
        own_q <= OWN_NONE;
      else if (own_q == OWN_NONE) begin
        if (hi_req_i && !lo_req_i)
          own_q <= OWN_HI;
        else if (lo_req_i && !hi_req_i)
          own_q <= OWN_LO;
      end
    end
  end

  assign hi_o = (own_q == OWN_HI) && (dead_q == '0) && !trip_i;
  assign lo_o = (own_q == OWN_LO) && (dead_q == '0) && !trip_i;

  // Checker state: consecutive cycles with both outputs off, saturating.
  logic [DW-1:0] idle_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idle_q <= DW'(N_DEAD);
    else if (hi_o || lo_o)
      idle_q <= '0;
    else if (idle_q != DW'(N_DEAD))
      idle_q <= idle_q + 1'b1;
  end

  // R7
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hi_o) || $rose(lo_o)) |-> (idle_q == DW'(N_DEAD)));

  // R6
  first_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((own_q == OWN_HI) && hi_req_i && !trip_i) |=> (own_q == OWN_HI));

  // R8
  tie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((own_q == OWN_NONE) && hi_req_i && lo_req_i) |=> !hi_o && !lo_o);
endmodule

// File: rtl/gate_interlock.sv
module gate_interlock #(
  parameter int N_LEGS = 3,
  parameter int N_FILT = 36,
  parameter int N_DEAD = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LEGS-1:0] cmd_hi_i,
  input  logic [N_LEGS-1:0] cmd_lo_i,
  input  logic              trip_i,
  output logic [N_LEGS-1:0] gate_hi_o,
  output logic [N_LEGS-1:0] gate_lo_o
);
  localparam int NCH = 2 * N_LEGS;

  logic [NCH-1:0] sync_w, filt_w;

  gi_sync #(.W(NCH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cmd_lo_i, cmd_hi_i}),
    .q_o   (sync_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_filt
    gi_filter #(.N_FILT(N_FILT)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (sync_w[c]),
      .lvl_o (filt_w[c])
    );
  end

  for (genvar l = 0; l < N_LEGS; l++) begin : g_leg
    gi_arbiter #(.N_DEAD(N_DEAD)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .hi_req_i (filt_w[l]),
      .lo_req_i (filt_w[N_LEGS + l]),
      .trip_i   (trip_i),
      .hi_o     (gate_hi_o[l]),
      .lo_o     (gate_lo_o[l])
    );
  end

  // R5
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi_o & gate_lo_o) == '0);

  // R10
  trip_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trip_i) |-> ((gate_hi_o == '0) && (gate_lo_o == '0)));
endmodule

// File: tb/gate_interlock_bench.sv
module gate_interlock_bench;
  localparam int F = 6;
  localparam int D = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hi = '0, lo = '0;
  logic       trip = 1'b0;
  logic [2:0] g_hi, g_lo;

  gate_interlock #(.N_LEGS(3), .N_FILT(F), .N_DEAD(D)) u_gate_interlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_hi_i  (hi),
    .cmd_lo_i  (lo),
    .trip_i    (trip),
    .gate_hi_o (g_hi),
    .gate_lo_o (g_lo)
  );

  always #4 clk = ~clk;

  typedef struct {
    int         cyc;
    logic [5:0] val;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int   ncyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 0;

  always @(posedge clk) ncyc <= ncyc + 1;

  task automatic push(input int dc, input logic [2:0] h, input logic [2:0] l,
                      input string tag);
    exp_t e;
    e.cyc = ncyc + dc;
    e.val = {h, l};
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    repeat (30) step();
  endtask

  // Monitor: pops expected items and compares them away from the edge.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= ncyc) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if (it.cyc != ncyc || {g_hi, g_lo} !== it.val) begin
        fails++;
        $display("FAIL %s cyc %0d: actual hi=%b lo=%b expected hi=%b lo=%b",
                 it.tag, ncyc, g_hi, g_lo, it.val[5:3], it.val[2:0]);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (5) step();
    // R1: reset state
    rst_n = 1'b1;
    push(0, 3'b000, 3'b000, "R1");
    push(3, 3'b000, 3'b000, "R1");
    settle();

    // R3: single request latency
    step(); hi = 3'b001;
    push(F+2, 3'b000, 3'b000, "R3");
    push(F+3, 3'b001, 3'b000, "R3");
    settle();

    // R4: short dropout on owned request
    step(); hi = 3'b000;
    push(F+2, 3'b001, 3'b000, "R4");
    push(F+4, 3'b001, 3'b000, "R4");
    push(2*F+2, 3'b001, 3'b000, "R4");
    repeat (F-1) step();
    hi = 3'b001;
    settle();

    // R6 / R5: late opposite request on owned leg
    step(); lo = 3'b001;
    push(F+3, 3'b001, 3'b000, "R6");
    push(F+8, 3'b001, 3'b000, "R5");
    settle();

    // R7: handover with deadtime
    step(); hi = 3'b000;
    push(F+2, 3'b001, 3'b000, "R7");
    push(F+3, 3'b000, 3'b000, "R7");
    push(F+2+D, 3'b000, 3'b000, "R7");
    push(F+3+D, 3'b000, 3'b001, "R7");
    settle();
    step(); lo = 3'b000;
    push(F+2, 3'b000, 3'b001, "R7");
    push(F+3, 3'b000, 3'b000, "R7");
    settle();

    // R2: pulse one cycle short of the filter time
    step(); hi = 3'b010;
    for (int k = 1; k <= 2*F+4; k++) push(k, 3'b000, 3'b000, "R2");
    repeat (F-1) step();
    hi = 3'b000;
    settle();

    // R2: pulse of exactly the filter time
    step(); hi = 3'b010;
    push(F+2, 3'b000, 3'b000, "R2");
    push(F+3, 3'b010, 3'b000, "R2");
    push(2*F+2, 3'b010, 3'b000, "R2");
    push(2*F+3, 3'b000, 3'b000, "R2");
    repeat (F) step();
    hi = 3'b000;
    settle();

    // R8: simultaneous requests on leg W
    step(); hi = 3'b100; lo = 3'b100;
    push(F+3, 3'b000, 3'b000, "R8");
    push(F+10, 3'b000, 3'b000, "R8");
    repeat (F+12) step();
    lo = 3'b000;
    push(F+2, 3'b000, 3'b000, "R8");
    push(F+3, 3'b100, 3'b000, "R8");
    settle();
    hi = 3'b000;
    settle();

    // R9 / R10: trip over a held request
    step(); hi = 3'b001;
    settle();
    step(); trip = 1'b1;
    push(0, 3'b000, 3'b000, "R9");
    push(4, 3'b000, 3'b000, "R9");
    repeat (8) step();
    trip = 1'b0;
    push(D-1, 3'b000, 3'b000, "R10");
    push(D, 3'b001, 3'b000, "R10");
    settle();
    hi = 3'b000;
    settle();

    // R11: independent legs
    step(); hi = 3'b001; lo = 3'b010;
    push(F+3, 3'b001, 3'b010, "R11");
    repeat (F+6) step();
    hi = 3'b000;
    push(F+3, 3'b000, 3'b010, "R11");
    settle();
    lo = 3'b000;
    settle();

    if (sb.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    finish_run();
  end
endmodule